// File: doc/BRIEF.md
# Satellite Frame Unique Word Synchronizer

This block finds and holds frame alignment in a stream of decided BPSK symbols from a satellite broadcast receiver. It takes one hard-decision bit per symbol with a valid strobe. It keeps the last 20 decided bits in a window and compares that window against three fixed 20-bit patterns. The patterns are a front word, a back word, and the bitwise complement of the back word. The first-received bit of a pattern is its most significant bit.

While unsynchronized, the block hunts for the front word at any position. A hit presets a symbol position counter so that it lines up with the frame. From then on, the block looks only at two fixed points in each frame. The first is the end of the front word, where the counter reaches 32. The second is the end of the back word, where the counter reaches 192. A hit at a check point raises a confidence level and a miss lowers it. Lock is reported while the level is 2 or higher. When the level returns to 0, the hunt starts again.

Downstream logic uses the lock flag and the position counter to find the header and the data slots. It uses the polarity flag to learn which form of the back word was last received.

Top module: `uw_frame_sync`

## Requirements
- R1: After reset, `frame_lock` is 0, `sym_pos` is 0 and `back_inverted` is 0.
- R2: While unsynchronized, suppose a valid symbol completes a 20-bit window equal to 0xECD28, where the oldest bit is the MSB. Then on the next cycle `sym_pos` is 32 and the confidence level is 1, so `frame_lock` stays 0.
- R3: While synchronized, `sym_pos` advances by one per valid symbol and holds when `sym_valid` is low. It wraps from FRAME_LEN-1 to 0.
- R4: Suppose the symbol that moves `sym_pos` to 192 completes the back word 0x0B677. Then the confidence level rises by one. `frame_lock` is 1 whenever the level is 2 or more.
- R5: The complement 0xF4988 is accepted at the back check point in the same way as the back word. `back_inverted` is set to 1 after a complemented hit and cleared to 0 after a plain hit.
- R6: The symbol that moves `sym_pos` to 32 is a check point. A front word there raises the level by one. The level never exceeds 4: a hit at level 4 leaves it at 4.
- R7: A miss at either check point lowers the level by one. `frame_lock` falls to 0 when the level drops below 2.
- R8: While the level is nonzero, pattern matches at positions other than the two check points leave the level and the count unaffected. When the level reaches 0, `sym_pos` returns to 0 and the front-word hunt restarts.
- R9: A window matches a pattern when it differs from that pattern in at most MAX_ERR bits. With the default MAX_ERR of 0, a single flipped bit prevents a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_valid | input | 1 | High for one cycle per received symbol |
| sym_bit | input | 1 | Hard-decision BPSK bit of the current symbol |
| frame_lock | output | 1 | Frame synchronization established (level >= 2) |
| sym_pos | output | $clog2(FRAME_LEN) | Symbols since frame start; 0 while hunting |
| back_inverted | output | 1 | Last accepted back word was the complemented form |

## Verification
The embedded properties take three things for granted. First, `sym_valid` and `sym_bit` are known values in every cycle after reset. Second, FRAME_LEN exceeds 192, so both check points fall inside one frame. Third, every register update is gated by `sym_valid`. The stimulus drives only defined bits on the falling edge and holds `sym_valid` low between segments. It builds each frame from zero filler, with the patterns placed exactly where a real frame puts them. Because of this, no shifted window of filler and pattern can mimic another pattern, and every hit the bench expects comes from a deliberately placed word.

// File: rtl/uw_sync_pkg.sv
package uw_sync_pkg;

  localparam int WORD_W        = 20;
  localparam int CONF_W        = 3;
  localparam int CONF_MAX      = 4;
  localparam int LOCK_LEVEL    = 2;
  localparam int FRONT_END_POS = 32;
  localparam int BACK_END_POS  = 192;
  localparam int NUM_PATTERNS  = 3;

  localparam logic [WORD_W-1:0] FRONT_WORD = 20'hECD28;
  localparam logic [WORD_W-1:0] BACK_WORD  = 20'h0B677;

  typedef enum int {
    PAT_FRONT    = 0,
    PAT_BACK     = 1,
    PAT_BACK_INV = 2
  } pat_sel_e;

  typedef struct packed {
    logic front;
    logic back;
    logic back_inv;
  } uw_hits_t;

  function automatic logic [WORD_W-1:0] uw_pattern(input int idx);
    case (idx)
      PAT_FRONT:    return FRONT_WORD;
      PAT_BACK:     return BACK_WORD;
      default:      return ~BACK_WORD;
    endcase
  endfunction

endpackage

// File: rtl/uw_bit_window.sv
module uw_bit_window #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] cand
);

  logic [W-2:0] hist_q;
  logic [W-2:0] hist_n;

  // Candidate window: the W-1 stored bits plus the bit arriving now (LSB).
  always_comb begin
    cand   = {hist_q, bit_in};
    hist_n = cand[W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_n;
    end
  end

endmodule

// File: rtl/uw_pattern_match.sv
module uw_pattern_match #(
  parameter int           W       = 20,
  parameter logic [W-1:0] PATTERN = '0,
  parameter int           MAX_ERR = 0
) (
  input  logic [W-1:0] cand,
  output logic         hit
);

  localparam int ERR_W = $clog2(W + 1);

  logic [W-1:0]     diff;
  logic [ERR_W-1:0] errs;

  always_comb begin
    diff = cand ^ PATTERN;
    errs = '0;
    for (int i = 0; i < W; i++) begin
      errs = errs + ERR_W'(diff[i]);
    end
    hit = (int'(errs) <= MAX_ERR);
  end

endmodule

// File: rtl/uw_frame_ctrl.sv
module uw_frame_ctrl
  import uw_sync_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  uw_hits_t          hits,
  output logic [CNT_W-1:0]  cnt,
  output logic [CONF_W-1:0] conf,
  output logic              back_inv
);

  localparam logic [CNT_W-1:0]  POS_FRONT  = CNT_W'(FRONT_END_POS);
  localparam logic [CNT_W-1:0]  POS_BACK   = CNT_W'(BACK_END_POS);
  localparam logic [CNT_W-1:0]  POS_LAST   = CNT_W'(FRAME_LEN - 1);
  localparam logic [CONF_W-1:0] CONF_TOP   = CONF_W'(CONF_MAX);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CONF_W-1:0] conf_q, conf_n;
  logic              inv_q, inv_n;
  logic              at_front, at_back, back_any;
  logic [CONF_W-1:0] conf_up, conf_dn;

  always_comb begin
    at_front = (cnt_q == POS_FRONT - 1'b1);
    at_back  = (cnt_q == POS_BACK - 1'b1);
    back_any = hits.back | hits.back_inv;
    conf_up  = (conf_q == CONF_TOP) ? CONF_TOP : conf_q + 1'b1;
    conf_dn  = (conf_q == '0) ? '0 : conf_q - 1'b1;

    cnt_n  = cnt_q;
    conf_n = conf_q;
    inv_n  = inv_q;

    if (conf_q == '0) begin
      cnt_n = '0;
      if (hits.front) begin
        conf_n = CONF_W'(1);
        cnt_n  = POS_FRONT;
      end
    end else begin
      cnt_n = (cnt_q == POS_LAST) ? '0 : cnt_q + 1'b1;
      if (at_front) begin
        conf_n = hits.front ? conf_up : conf_dn;
      end else if (at_back) begin
        conf_n = back_any ? conf_up : conf_dn;
        if (back_any) begin
          inv_n = ~hits.back;
        end
      end
      if (conf_n == '0) begin
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      conf_q <= '0;
      inv_q  <= 1'b0;
    end else if (sym_valid) begin
      cnt_q  <= cnt_n;
      conf_q <= conf_n;
      inv_q  <= inv_n;
    end
  end

  assign cnt      = cnt_q;
  assign conf     = conf_q;
  assign back_inv = inv_q;

  // R3
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> ($stable(cnt_q) && $stable(conf_q) && $stable(inv_q)));

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= POS_LAST);

  // R6
  conf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conf_q <= CONF_TOP);

  // R2
  acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && conf_q == '0 && hits.front) |=>
      (conf_q == CONF_W'(1) && cnt_q == POS_FRONT));

  // R8
  hunt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_q == '0) |-> (cnt_q == '0));

  // R8
  offpoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && conf_q != '0 && !at_front && !at_back) |=> $stable(conf_q));

  // R7
  conf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && conf_q != '0) |=>
      (conf_q == $past(conf_q) || conf_q == $past(conf_q) + 1'b1 ||
       conf_q + 1'b1 == $past(conf_q)));

endmodule

// File: rtl/uw_frame_sync.sv
module uw_frame_sync
  import uw_sync_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  parameter int MAX_ERR   = 0,
  localparam int CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             sym_bit,
  output logic             frame_lock,
  output logic [CNT_W-1:0] sym_pos,
  output logic             back_inverted
);

  logic                    rst_meta_q, rst_sync_q;
  logic [WORD_W-1:0]       cand;
  logic [NUM_PATTERNS-1:0] hit_vec;
  uw_hits_t                hits;
  logic [CONF_W-1:0]       conf;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  uw_bit_window #(.W(WORD_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .shift_en (sym_valid),
    .bit_in   (sym_bit),
    .cand     (cand)
  );

  for (genvar g = 0; g < NUM_PATTERNS; g++) begin : g_match
    uw_pattern_match #(
      .W       (WORD_W),
      .PATTERN (uw_pattern(g)),
      .MAX_ERR (MAX_ERR)
    ) u_match (
      .cand (cand),
      .hit  (hit_vec[g])
    );
  end

  always_comb begin
    hits.front    = hit_vec[PAT_FRONT];
    hits.back     = hit_vec[PAT_BACK];
    hits.back_inv = hit_vec[PAT_BACK_INV];
  end

  uw_frame_ctrl #(
    .FRAME_LEN (FRAME_LEN),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .sym_valid (sym_valid),
    .hits      (hits),
    .cnt       (sym_pos),
    .conf      (conf),
    .back_inv  (back_inverted)
  );

  assign frame_lock = (conf >= CONF_W'(LOCK_LEVEL));

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(frame_lock) |-> (sym_pos == CNT_W'(FRONT_END_POS) || sym_pos == CNT_W'(BACK_END_POS)));

endmodule

// File: tb/uw_frame_sync_bench.sv
`timescale 1ns/1ps
module uw_frame_sync_bench;

  localparam int FL    = 512;
  localparam int CW    = $clog2(FL);
  localparam logic [19:0] FW = 20'hECD28;
  localparam logic [19:0] BW = 20'h0B677;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sym_valid;
  logic          sym_bit;
  logic          frame_lock;
  logic [CW-1:0] sym_pos;
  logic          back_inverted;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  uw_frame_sync #(.FRAME_LEN(FL), .MAX_ERR(0)) u_uw_frame_sync (
    .clk           (clk),
    .rst_n         (rst_n),
    .sym_valid     (sym_valid),
    .sym_bit       (sym_bit),
    .frame_lock    (frame_lock),
    .sym_pos       (sym_pos),
    .back_inverted (back_inverted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fk: 0 clean front word, 1 front word with one bit flipped
  // bk: 0 zeros, 1 back word, 2 complemented back word, 3 back word with one bit flipped
  function automatic logic bit_at(input int idx, input int fk, input int bk, input bit stray);
    logic [19:0] f, b;
    f = (fk == 1) ? (FW ^ 20'h00400) : FW;
    case (bk)
      1:       b = BW;
      2:       b = ~BW;
      3:       b = BW ^ 20'h00010;
      default: b = 20'h0;
    endcase
    if (idx >= 12 && idx <= 31)        return f[31 - idx];
    if (stray && idx >= 60 && idx <= 79) return FW[79 - idx];
    if (idx >= 172 && idx <= 191)      return b[191 - idx];
    return 1'b0;
  endfunction

  task automatic send(input int lo, input int hi, input int fk, input int bk, input bit stray);
    for (int i = lo; i <= hi; i++) begin
      @(negedge clk);
      sym_valid = 1'b1;
      sym_bit   = bit_at(i, fk, bk, stray);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    sym_valid = 1'b0;
    sym_bit   = 1'b0;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 lock", frame_lock, 0);
    chk("R1 pos", sym_pos, 0);
    chk("R1 inv", back_inverted, 0);
  endtask

  task automatic t_acquire();
    send(0, 31, 0, 1, 0);
    settle();
    chk("R2 pos", sym_pos, 32);
    chk("R2 lock", frame_lock, 0);
    for (int k = 0; k < 5; k++) settle();
    chk("R3 hold", sym_pos, 32);
    send(32, 191, 0, 1, 0);
    settle();
    chk("R3 advance", sym_pos, 192);
    chk("R4 lock", frame_lock, 1);
    chk("R5 plain", back_inverted, 0);
    send(192, FL - 1, 0, 1, 0);
    settle();
    chk("R3 wrap", sym_pos, 0);
    chk("R4 lock kept", frame_lock, 1);
  endtask

  task automatic t_inverted();
    send(0, 191, 0, 2, 0);
    settle();
    chk("R5 inv set", back_inverted, 1);
    chk("R5 lock", frame_lock, 1);
    send(192, FL - 1, 0, 2, 0);
    send(0, 191, 0, 1, 0);
    settle();
    chk("R5 inv clear", back_inverted, 0);
    send(192, FL - 1, 0, 1, 0);
  endtask

  task automatic t_saturate();
    // level is 4 (saturated); two misses leave 2, third leaves 1
    send(0, FL - 1, 1, 3, 0);
    settle();
    chk("R7 lock at 2", frame_lock, 1);
    send(0, 31, 1, 0, 0);
    settle();
    chk("R6 R7 lock drop", frame_lock, 0);
    chk("R7 pos", sym_pos, 32);
  endtask

  task automatic t_stray();
    send(32, 99, 0, 3, 1);
    settle();
    chk("R8 stray pos", sym_pos, 100);
    chk("R8 stray lock", frame_lock, 0);
    send(100, 191, 0, 3, 0);
    settle();
    chk("R8 fall pos", sym_pos, 0);
    send(192, FL - 1, 0, 0, 0);
    settle();
    chk("R8 hunt pos", sym_pos, 0);
  endtask

  task automatic t_tolerance();
    send(0, 31, 1, 0, 0);
    settle();
    chk("R9 no match", sym_pos, 0);
    send(32, FL - 1, 0, 0, 0);
    send(0, 31, 0, 1, 0);
    settle();
    chk("R2 reacquire", sym_pos, 32);
    send(32, 191, 0, 1, 0);
    settle();
    chk("R4 relock", frame_lock, 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    sym_valid = 1'b0;
    sym_bit   = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_acquire();
    t_inverted();
    t_saturate();
    t_stray();
    t_tolerance();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule